// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sequences low-power states for a small microcontroller core. The core raises a sleep request. The block samples a 3-bit mode select, a brown-out-detector sleep-off bit and an ADC-enabled flag at that moment. It then drops the clock enables for the CPU, flash and (in one mode) I/O domains. It can switch off the brown-out detector for the sleep period. When the ADC is enabled, it fires a one-cycle ADC auto-start pulse.

While asleep it watches a 10-bit wake-source vector, filtered by the latched mode. Bit positions: 0 ADC conversion done, 1 external reset, 2 watchdog, 3 brown-out reset, 4 serial-bus address match, 5 asynchronous timer, 6 nonvolatile-memory ready, 7 external level interrupt, 8 pin change, 9 any other enabled interrupt.

On a wake the clocks come back at once if the detector stayed on. If the detector was off, it is re-enabled at once and the clocks stay gated for a settling window of `CLK_KHZ*WAKE_US/1000` cycles. With the defaults this is 3000 cycles, or 60 µs at 50 MHz.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After synchronous reset every clock enable and `bod_en` read 1 and `adc_start` reads 0.
- R2: A request with mode 000 (light sleep) accepted while running gives `cpu_clk_en`=`flash_clk_en`=0 and `io_clk_en`=`adc_clk_en`=1 one cycle later.
- R3: A request with mode 001 (ADC quiet sleep) gives `cpu_clk_en`, `flash_clk_en` and `io_clk_en` at 0 and `adc_clk_en` at 1 one cycle later.
- R4: A request with any mode from 010 to 111 is ignored and all enables stay 1.
- R5: `adc_start` is a single-cycle pulse, due in the same cycle as the gated enables. It only occurs when `adc_enabled` was 1 at the accepted request.
- R6: In light sleep, any of wake bits 0 to 9 restores all enables one cycle later, provided the detector stayed on.
- R7: In ADC quiet sleep, only wake bits 0 to 8 wake the block, and bit 9 alone leaves it asleep.
- R8: With `bod_sleep_off`=1 at the request, `bod_en` is 0 one cycle after entry. With `bod_sleep_off`=0, `bod_en` stays 1 through sleep.
- R9: On a wake with the detector off, `bod_en` returns to 1 one cycle after the wake. The clock enables return exactly the settling-window number of cycles after that, and `cpu_clk_en` is never 1 while `bod_en` is 0.
- R10: A sleep request arriving while asleep or during the settling window is ignored.
- R11: Mode and detector-off choices are latched at entry, and changes to those inputs during sleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request from the core |
| mode_sel | input | 3 | Sleep mode select (000 light, 001 ADC quiet) |
| bod_sleep_off | input | 1 | Switch the brown-out detector off while asleep |
| adc_enabled | input | 1 | ADC is enabled (auto-start on entry) |
| wake_src | input | 10 | Wake event vector, one bit per source |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| bod_en | output | 1 | Brown-out detector enable |
| adc_start | output | 1 | One-cycle ADC conversion start |

## Verification
All outputs are registered, so a request or wake event sampled at one edge shows up after that same edge. The bench therefore expects the result one cycle after it drives the stimulus. The exception is the clock restore after a detector-off sleep, which is due exactly one settling window after `bod_en` rises. For that case the bench schedules checks for the last gated cycle and the first running cycle.

Each expected item carries its due cycle number. The monitor compares the outputs in that cycle, sampling mid-period, and flags any item whose cycle has passed.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE   = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_WAKE_DLY = 2'd2
  } pm_state_t;

  localparam logic [2:0] MODE_LIGHT     = 3'b000;
  localparam logic [2:0] MODE_ADC_QUIET = 3'b001;

  // wake vector layout; bit 9 = generic interrupt, not accepted in ADC quiet mode
  localparam int WAKE_W = 10;
  localparam logic [WAKE_W-1:0] QUIET_WAKE_MASK = 10'b01_1111_1111;

  function automatic logic mode_is_valid(input logic [2:0] m);
    return (m == MODE_LIGHT) || (m == MODE_ADC_QUIET);
  endfunction
endpackage

// File: rtl/pm_wake_filter.sv
module pm_wake_filter
  import sleep_ctrl_pkg::*;
#(
  parameter int W = WAKE_W,
  parameter logic [W-1:0] QUIET_MASK = QUIET_WAKE_MASK
) (
  input  logic [W-1:0] wake_src,
  input  logic         quiet_mode,
  output logic         wake_hit
);
  logic [W-1:0] passed;

  for (genvar i = 0; i < W; i++) begin : g_src
    assign passed[i] = wake_src[i] & (QUIET_MASK[i] | ~quiet_mode);
  end

  assign wake_hit = |passed;
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import sleep_ctrl_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3000,
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic [2:0] mode_sel,
  input  logic       bod_sleep_off,
  input  logic       wake_hit,
  output pm_state_t  state_nx,
  output logic       quiet_q,
  output logic       quiet_nx,
  output logic       bod_off_nx,
  output logic       enter
);
  pm_state_t        state_q;
  logic             bod_off_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  assign enter = (state_q == ST_ACTIVE) && sleep_req && mode_is_valid(mode_sel);

  always_comb begin
    state_nx   = state_q;
    quiet_nx   = quiet_q;
    bod_off_nx = bod_off_q;
    cnt_nx     = cnt_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (enter) begin
          state_nx   = ST_SLEEP;
          quiet_nx   = (mode_sel == MODE_ADC_QUIET);
          bod_off_nx = bod_sleep_off;
        end
      end
      ST_SLEEP: begin
        if (wake_hit) begin
          if (bod_off_q) begin
            state_nx = ST_WAKE_DLY;
            cnt_nx   = CNT_W'(SETTLE_CYCLES - 1);
          end else begin
            state_nx = ST_ACTIVE;
          end
          bod_off_nx = 1'b0;
        end
      end
      ST_WAKE_DLY: begin
        if (cnt_q == '0) state_nx = ST_ACTIVE;
        else             cnt_nx   = cnt_q - 1'b1;
      end
      default: state_nx = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACTIVE;
      quiet_q   <= 1'b0;
      bod_off_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      state_q   <= state_nx;
      quiet_q   <= quiet_nx;
      bod_off_q <= bod_off_nx;
      cnt_q     <= cnt_nx;
    end
  end
endmodule

// File: rtl/pm_enable_regs.sv
module pm_enable_regs
  import sleep_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_t state_nx,
  input  logic      quiet_nx,
  input  logic      bod_off_nx,
  input  logic      enter,
  input  logic      adc_enabled,
  output logic      cpu_clk_en,
  output logic      flash_clk_en,
  output logic      io_clk_en,
  output logic      adc_clk_en,
  output logic      bod_en,
  output logic      adc_start
);
  logic running;
  assign running = (state_nx == ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en   <= 1'b1;
      flash_clk_en <= 1'b1;
      io_clk_en    <= 1'b1;
      adc_clk_en   <= 1'b1;
      bod_en       <= 1'b1;
      adc_start    <= 1'b0;
    end else begin
      cpu_clk_en   <= running;
      flash_clk_en <= running;
      io_clk_en    <= running | ~quiet_nx;
      adc_clk_en   <= 1'b1;
      bod_en       <= ~((state_nx == ST_SLEEP) & bod_off_nx);
      adc_start    <= enter & adc_enabled;
    end
  end
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int CLK_KHZ = 50000,
  parameter int WAKE_US = 60,
  localparam int RAW_CYC = CLK_KHZ * WAKE_US / 1000,
  localparam int SETTLE_CYCLES = (RAW_CYC < 1) ? 1 : RAW_CYC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic [2:0]        mode_sel,
  input  logic              bod_sleep_off,
  input  logic              adc_enabled,
  input  logic [WAKE_W-1:0] wake_src,
  output logic              cpu_clk_en,
  output logic              flash_clk_en,
  output logic              io_clk_en,
  output logic              adc_clk_en,
  output logic              bod_en,
  output logic              adc_start
);
  pm_state_t state_nx;
  logic      quiet_q, quiet_nx, bod_off_nx, enter, wake_hit;

  pm_wake_filter #(.W(WAKE_W), .QUIET_MASK(QUIET_WAKE_MASK)) u_filter (
    .wake_src   (wake_src),
    .quiet_mode (quiet_q),
    .wake_hit   (wake_hit)
  );

  pm_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .sleep_req     (sleep_req),
    .mode_sel      (mode_sel),
    .bod_sleep_off (bod_sleep_off),
    .wake_hit      (wake_hit),
    .state_nx      (state_nx),
    .quiet_q       (quiet_q),
    .quiet_nx      (quiet_nx),
    .bod_off_nx    (bod_off_nx),
    .enter         (enter)
  );

  pm_enable_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .state_nx     (state_nx),
    .quiet_nx     (quiet_nx),
    .bod_off_nx   (bod_off_nx),
    .enter        (enter),
    .adc_enabled  (adc_enabled),
    .cpu_clk_en   (cpu_clk_en),
    .flash_clk_en (flash_clk_en),
    .io_clk_en    (io_clk_en),
    .adc_clk_en   (adc_clk_en),
    .bod_en       (bod_en),
    .adc_start    (adc_start)
  );
endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sleep_req,
  input logic [2:0] mode_sel,
  input logic       bod_sleep_off,
  input logic       adc_enabled,
  input logic       cpu_clk_en,
  input logic       flash_clk_en,
  input logic       io_clk_en,
  input logic       adc_clk_en,
  input logic       bod_en,
  input logic       adc_start
);
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (cpu_clk_en && flash_clk_en && io_clk_en && adc_clk_en && bod_en && !adc_start));

  p_light_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && mode_sel == 3'b000)
      |=> (!cpu_clk_en && !flash_clk_en && io_clk_en && adc_clk_en));

  p_cpu_flash_pair_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en == flash_clk_en);

  p_quiet_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && mode_sel == 3'b001)
      |=> (!cpu_clk_en && !io_clk_en && adc_clk_en));

  p_reserved_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && mode_sel[2:1] != 2'b00) |=> cpu_clk_en);

  p_start_single_r5: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  p_start_cause_r5: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $past(adc_enabled && sleep_req && cpu_clk_en));

  p_bod_off_entry_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && mode_sel[2:1] == 2'b00 && bod_sleep_off) |=> !bod_en);

  p_bod_gates_cpu_r9: assert property (@(posedge clk) disable iff (rst)
    !bod_en |-> !cpu_clk_en);

  p_bod_first_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bod_en) |-> !cpu_clk_en);

  p_light_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && io_clk_en) |=> io_clk_en);
endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .sleep_req     (sleep_req),
  .mode_sel      (mode_sel),
  .bod_sleep_off (bod_sleep_off),
  .adc_enabled   (adc_enabled),
  .cpu_clk_en    (cpu_clk_en),
  .flash_clk_en  (flash_clk_en),
  .io_clk_en     (io_clk_en),
  .adc_clk_en    (adc_clk_en),
  .bod_en        (bod_en),
  .adc_start     (adc_start)
);

// File: tb/sleep_clk_ctrl_test.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_test;
  localparam int WC = 50000 * 60 / 1000;
  // vector order: {cpu, flash, io, adc, bod, start}
  localparam logic [5:0] RUN = 6'b111110;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       bod_sleep_off = 1'b0;
  logic       adc_enabled = 1'b0;
  logic [9:0] wake_src = '0;
  logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, bod_en, adc_start;

  typedef struct { int due; logic [5:0] v; string tag; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sleep_clk_ctrl uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .mode_sel(mode_sel),
    .bod_sleep_off(bod_sleep_off), .adc_enabled(adc_enabled), .wake_src(wake_src),
    .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
    .adc_clk_en(adc_clk_en), .bod_en(bod_en), .adc_start(adc_start)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int off, input logic [5:0] v, input string tag);
    item_t it;
    it.due = cyc + off; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: samples 15 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #15;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [5:0] act;
        it = q.pop_front();
        act = {cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, bod_en, adc_start};
        checks++;
        if (it.due != cyc || act !== it.v) begin
          errors++;
          $display("FAIL %s cycle %0d: actual=%b expected=%b", it.tag, it.due, act, it.v);
        end
      end
      if (cyc > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
      end
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    expect_at(0, RUN, "R1");
    tick();
    // reserved modes
    mode_sel = 3'b010; sleep_req = 1'b1; expect_at(1, RUN, "R4"); tick();
    mode_sel = 3'b111; expect_at(1, RUN, "R4"); tick();
    sleep_req = 1'b0; tick();
    // light sleep with ADC auto-start
    mode_sel = 3'b000; adc_enabled = 1'b1; sleep_req = 1'b1;
    expect_at(1, 6'b001111, "R2/R5"); expect_at(2, 6'b001110, "R5");
    tick(); sleep_req = 1'b0; tick();
    // new request while asleep
    mode_sel = 3'b001; sleep_req = 1'b1; expect_at(1, 6'b001110, "R10");
    tick(); sleep_req = 1'b0; tick();
    // generic interrupt wakes light sleep
    wake_src = 10'h200; expect_at(1, RUN, "R6"); tick(); wake_src = '0; tick();
    // ADC quiet sleep, no auto-start
    mode_sel = 3'b001; adc_enabled = 1'b0; sleep_req = 1'b1;
    expect_at(1, 6'b000110, "R3/R5"); tick(); sleep_req = 1'b0;
    wake_src = 10'h200; expect_at(1, 6'b000110, "R7"); tick();
    wake_src = 10'h100; expect_at(1, RUN, "R7"); tick(); wake_src = '0; tick();
    // detector off during quiet sleep
    adc_enabled = 1'b1; bod_sleep_off = 1'b1; sleep_req = 1'b1;
    expect_at(1, 6'b000101, "R8"); expect_at(2, 6'b000100, "R8");
    tick(); sleep_req = 1'b0; tick();
    bod_sleep_off = 1'b0; mode_sel = 3'b000; expect_at(1, 6'b000100, "R11"); tick();
    wake_src = 10'h001;
    expect_at(1, 6'b000110, "R9"); expect_at(WC, 6'b000110, "R9");
    expect_at(WC + 1, RUN, "R9"); expect_at(WC + 3, RUN, "R10");
    tick(); wake_src = '0; tick(3);
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    tick(WC + 3);
    // light sleep with detector kept on, wake from bus address match
    mode_sel = 3'b000; adc_enabled = 1'b0; bod_sleep_off = 1'b0; sleep_req = 1'b1;
    expect_at(1, 6'b001110, "R8"); tick(); sleep_req = 1'b0; tick();
    wake_src = 10'h010; expect_at(1, RUN, "R6"); tick(); wake_src = '0;
    tick(3);
    while (q.size() > 0) tick();
    finish_run();
  end
endmodule